// File: doc/BRIEF.md
# Serial Slave Shifter with Echo

This block is the slave end of a synchronous serial link. An external master supplies the shift clock and an active-low select. While select is active, the block shifts one word out on its serial data output and shifts one word in from its serial data input. A single word-wide data register serves both directions. The host writes the word to be sent into it, and a finished transfer replaces its contents with the word received. The word length is 8 or 16 bits, and the idle level of the shift clock is set by a configuration input.

All three serial pins are brought into the system clock domain through two-flop synchronisers. The data output changes on the clock edge that leaves the idle level, and the input is sampled on the edge that returns to it. If a transfer starts while the host has not loaded fresh data and echo is enabled, the block drives the incoming bits straight back out. It still captures them in the data register. A busy flag, a read-buffer-full flag and one interrupt line with two enables complete the host side.

Top module: `ser_slave_shifter`

## Requirements
- R1: `sdo_oe` is 1 exactly while the synchronised select is active (sel_n_in low, seen two clocks later) and 0 out of reset. The slave drives `sdo_data` only while `sdo_oe` is 1.
- R2: Clock edges have no effect while select is inactive. Raising select clears the bit count, so a partial transfer is dropped and the next selection starts from the first bit.
- R3: Bits go out most significant first. With `cfg_wide`=0 the slave sends bits 7 down to 0 of the data register. With `cfg_wide`=1 it sends bits 15 down to 0.
- R4: After 8 (`cfg_wide`=0) or 16 (`cfg_wide`=1) sampled bits, the received word is written to the data register and `rbf` is set. In 8-bit mode the received bits fill bits 7..0 and bits 15..8 are cleared. The first bit received ends up as the most significant bit.
- R5: If a transfer starts while the data register is not marked valid and `cfg_echo_en`=1, `sdo_data` follows the synchronised serial input for the whole transfer. The received word is still stored.
- R6: With `cfg_echo_en`=0, the slave sends the data register contents whether or not they were marked valid.
- R7: With `cfg_idle_hi`=0 the clock idles low: the output changes on rising edges and the input is sampled on falling edges. With `cfg_idle_hi`=1 both edges are inverted.
- R8: `irq` = (`rbf` and `cfg_rd_irq_en`) or (not `busy` and `cfg_wr_irq_en`).
- R9: `host_wr_en` loads `host_wr_data` and marks the register valid. A transfer start clears the valid mark. `host_rd_en` clears `rbf`, unless a transfer completes in the same cycle.
- R10: `busy` rises when a transfer starts and falls at completion or when select is released. It is 0 out of reset.
- R11: While select stays active after a completed transfer, the next leaving-idle clock edge starts a new transfer. That transfer sends the current data register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1: 16-bit words, 0: 8-bit words |
| cfg_idle_hi | input | 1 | Idle level of the shift clock |
| cfg_echo_en | input | 1 | Enable echo when no valid data is loaded |
| cfg_rd_irq_en | input | 1 | Interrupt enable for read-buffer-full |
| cfg_wr_irq_en | input | 1 | Interrupt enable for not-busy |
| host_wr_en | input | 1 | Host write strobe for the data register |
| host_wr_data | input | 16 | Host write data |
| host_rd_en | input | 1 | Host read strobe, clears rbf |
| host_rd_data | output | 16 | Data register contents |
| sck_in | input | 1 | Shift clock from the master |
| sel_n_in | input | 1 | Active-low select from the master |
| sdi_in | input | 1 | Serial data from the master |
| sdo_data | output | 1 | Serial data to the master |
| sdo_oe | output | 1 | Output enable for sdo_data |
| busy | output | 1 | Transfer in progress |
| rbf | output | 1 | Read buffer full |
| irq | output | 1 | Combined interrupt |

## Verification
A stale bit counter or a shift register that advanced at the wrong time shows up on `sdo_data` within one shift-clock half period. The master samples a wrong bit, and the received word in `host_rd_data` is misaligned as soon as the transfer ends. A valid mark that is set wrongly only shows when the next transfer starts with echo enabled, because the first output bit then comes from the register instead of from the input. Flags that stick show up on `busy`, `rbf` and `irq` in the cycle after the master releases select or the host reads. The bench compares every output on every clock against a behavioural model, so any of these faults is reported at the first cycle where it becomes visible.

// File: rtl/sss_pkg.sv
package sss_pkg;

    localparam int unsigned DEF_WORD_W   = 16;
    localparam int unsigned DEF_NARROW_W = 8;
    localparam int unsigned DEF_SYNC     = 2;

    // serial pins as seen after synchronisation
    typedef struct packed {
        logic sck;
        logic sel_n;
        logic sdi;
    } pin_t;

    // clock low, select released, data low
    localparam pin_t PIN_RESET = '{sck: 1'b0, sel_n: 1'b1, sdi: 1'b0};

    // events produced by the edge detector for the shifter
    typedef struct packed {
        logic leave;   // clock leaves its idle level
        logic ret;     // clock returns to its idle level
        logic sel_on;  // select currently active
        logic first;   // select became active this cycle
    } evt_t;

    // word length in bits for a given width setting
    function automatic int unsigned frame_bits(input logic wide,
                                               input int unsigned narrow_w,
                                               input int unsigned word_w);
        return wide ? word_w : narrow_w;
    endfunction

endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sss_edge.sv
module sss_edge
    import sss_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic idle_hi,
    input  logic sck_s,
    input  logic sel_n_s,
    output evt_t evt
);
    logic sck_prev;
    logic sel_n_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev   <= PIN_RESET.sck;
            sel_n_prev <= PIN_RESET.sel_n;
        end else begin
            sck_prev   <= sck_s;
            sel_n_prev <= sel_n_s;
        end
    end

    always_comb begin
        evt.leave  = (sck_s != idle_hi) && (sck_prev == idle_hi);
        evt.ret    = (sck_s == idle_hi) && (sck_prev != idle_hi);
        evt.sel_on = !sel_n_s;
        evt.first  = !sel_n_s && sel_n_prev;
    end
endmodule

// File: rtl/sss_core.sv
module sss_core
    import sss_pkg::*;
#(
    parameter int unsigned WORD_W   = DEF_WORD_W,
    parameter int unsigned NARROW_W = DEF_NARROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              evt,
    input  logic              sdi,
    input  logic              wide,
    input  logic              echo_en,
    input  logic              data_valid,
    input  logic [WORD_W-1:0] data_word,
    output logic              busy,
    output logic              start,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sdo_bit
);
    localparam int unsigned CW   = $clog2(WORD_W);
    localparam int unsigned PADW = WORD_W - NARROW_W;

    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-2:0] rx_sh;
    logic [CW-1:0]     cnt;
    logic              busy_q;
    logic              adv_q;
    logic              echo_q;
    logic              last_bit;
    logic [WORD_W-1:0] tx_load;
    logic [WORD_W-1:0] rx_full;

    assign last_bit = (cnt == CW'(frame_bits(wide, NARROW_W, WORD_W) - 1));
    assign tx_load  = wide ? data_word : {data_word[NARROW_W-1:0], {PADW{1'b0}}};
    assign rx_full  = {rx_sh, sdi};
    assign rx_word  = wide ? rx_full : {{PADW{1'b0}}, rx_full[NARROW_W-1:0]};

    assign start = evt.sel_on && (evt.first || (evt.leave && !busy_q));
    assign done  = evt.sel_on && !start && busy_q && evt.ret && last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            cnt    <= '0;
            busy_q <= 1'b0;
            adv_q  <= 1'b0;
            echo_q <= 1'b0;
        end else if (!evt.sel_on) begin
            // released select realigns the bit count
            cnt    <= '0;
            busy_q <= 1'b0;
            adv_q  <= 1'b0;
            echo_q <= 1'b0;
        end else if (start) begin
            tx_sh  <= tx_load;
            cnt    <= '0;
            busy_q <= 1'b1;
            adv_q  <= 1'b0;
            echo_q <= echo_en && !data_valid;
        end else if (busy_q) begin
            // one output advance is allowed per sampled bit
            if (evt.leave && adv_q) begin
                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                adv_q <= 1'b0;
            end
            if (evt.ret) begin
                rx_sh <= rx_full[WORD_W-2:0];
                adv_q <= 1'b1;
                if (last_bit) begin
                    cnt    <= '0;
                    busy_q <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign sdo_bit = echo_q ? sdi : tx_sh[WORD_W-1];
endmodule

// File: rtl/ser_slave_shifter.sv
module ser_slave_shifter
    import sss_pkg::*;
#(
    parameter int unsigned WORD_W      = DEF_WORD_W,
    parameter int unsigned NARROW_W    = DEF_NARROW_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic              cfg_idle_hi,
    input  logic              cfg_echo_en,
    input  logic              cfg_rd_irq_en,
    input  logic              cfg_wr_irq_en,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wr_data,
    input  logic              host_rd_en,
    output logic [WORD_W-1:0] host_rd_data,
    input  logic              sck_in,
    input  logic              sel_n_in,
    input  logic              sdi_in,
    output logic              sdo_data,
    output logic              sdo_oe,
    output logic              busy,
    output logic              rbf,
    output logic              irq
);
    localparam int unsigned PIN_W = $bits(pin_t);

    pin_t              pin_raw;
    pin_t              pin_s;
    evt_t              evt;
    logic [WORD_W-1:0] data_q;
    logic              valid_q;
    logic              rbf_q;
    logic              core_busy;
    logic              core_start;
    logic              core_done;
    logic [WORD_W-1:0] core_rx;
    logic              core_sdo;

    assign pin_raw = '{sck: sck_in, sel_n: sel_n_in, sdi: sdi_in};

    sss_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RESET)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    sss_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .idle_hi (cfg_idle_hi),
        .sck_s   (pin_s.sck),
        .sel_n_s (pin_s.sel_n),
        .evt     (evt)
    );

    sss_core #(
        .WORD_W   (WORD_W),
        .NARROW_W (NARROW_W)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .sdi        (pin_s.sdi),
        .wide       (cfg_wide),
        .echo_en    (cfg_echo_en),
        .data_valid (valid_q),
        .data_word  (data_q),
        .busy       (core_busy),
        .start      (core_start),
        .done       (core_done),
        .rx_word    (core_rx),
        .sdo_bit    (core_sdo)
    );

    // data register: host write takes priority over a completing transfer
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            rbf_q   <= 1'b0;
        end else begin
            if (host_wr_en) begin
                data_q  <= host_wr_data;
                valid_q <= 1'b1;
            end else begin
                if (core_done)  data_q  <= core_rx;
                if (core_start) valid_q <= 1'b0;
            end
            if (core_done)       rbf_q <= 1'b1;
            else if (host_rd_en) rbf_q <= 1'b0;
        end
    end

    assign host_rd_data = data_q;
    assign sdo_oe       = evt.sel_on;
    assign sdo_data     = core_sdo;
    assign busy         = core_busy;
    assign rbf          = rbf_q;
    assign irq          = (rbf_q && cfg_rd_irq_en) || (!core_busy && cfg_wr_irq_en);
endmodule

// File: rtl/sss_checker.sv
module sss_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic rbf,
    input logic sdo_oe,
    input logic host_rd_en
);
    // R9: a read while nothing can complete leaves rbf clear
    p_rd_clears_rbf_r9: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && !busy) |=> !rbf);

    // R4: rbf only rises together with the end of a transfer
    p_rbf_at_done_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rbf) |-> $fell(busy));

    // R10: a transfer only starts while select was seen active
    p_start_needs_sel_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(sdo_oe));

    // R2: a released select leaves no transfer running
    p_released_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!sdo_oe && $past(!sdo_oe)) |-> !busy);

    // R10: busy ends by completion or by release of select
    p_busy_end_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!sdo_oe || rbf));
endmodule

bind ser_slave_shifter sss_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .rbf        (rbf),
    .sdo_oe     (sdo_oe),
    .host_rd_en (host_rd_en)
);

// File: tb/ser_slave_shifter_bench.sv
`timescale 1ns/1ps
module ser_slave_shifter_bench;
    localparam int HP = 6; // clocks per shift-clock half period

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wide = 1'b0, cfg_idle_hi = 1'b0, cfg_echo_en = 1'b0;
    logic        cfg_rd_irq_en = 1'b0, cfg_wr_irq_en = 1'b0;
    logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic [15:0] host_rd_data;
    logic        sck_in = 1'b0, sel_n_in = 1'b1, sdi_in = 1'b0;
    logic        sdo_data, sdo_oe, busy, rbf, irq;

    int n_chk = 0;
    int n_err = 0;
    bit model_on = 0;

    always #2.5 clk = ~clk;

    ser_slave_shifter u_ser_slave_shifter (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_idle_hi(cfg_idle_hi),
        .cfg_echo_en(cfg_echo_en), .cfg_rd_irq_en(cfg_rd_irq_en),
        .cfg_wr_irq_en(cfg_wr_irq_en), .host_wr_en(host_wr_en),
        .host_wr_data(host_wr_data), .host_rd_en(host_rd_en),
        .host_rd_data(host_rd_data), .sck_in(sck_in), .sel_n_in(sel_n_in),
        .sdi_in(sdi_in), .sdo_data(sdo_data), .sdo_oe(sdo_oe), .busy(busy),
        .rbf(rbf), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0]  m_p1, m_p2, m_p3;   // {sck, sel_n, sdi} delayed by clocks
    logic [15:0] m_data, m_tx, m_rx;
    bit          m_valid, m_rbf, m_busy, m_adv, m_echo;
    int          m_cnt;

    always @(posedge clk) begin
        bit sel, lv, rt, st, dn;
        if (rst) begin
            m_p1 = 3'b010; m_p2 = 3'b010; m_p3 = 3'b010;
            m_data = '0; m_tx = '0; m_rx = '0;
            m_valid = 0; m_rbf = 0; m_busy = 0; m_adv = 0; m_echo = 0; m_cnt = 0;
        end else begin
            sel = !m_p2[1];
            lv  = (m_p2[2] != cfg_idle_hi) && (m_p3[2] == cfg_idle_hi);
            rt  = (m_p2[2] == cfg_idle_hi) && (m_p3[2] != cfg_idle_hi);
            st = 0; dn = 0;
            if (!sel) begin
                m_busy = 0; m_cnt = 0; m_adv = 0; m_echo = 0;
            end else if ((m_p3[1] == 1'b1) || (lv && !m_busy)) begin
                st = 1;
                m_tx = cfg_wide ? m_data : {m_data[7:0], 8'h00};
                m_busy = 1; m_cnt = 0; m_adv = 0;
                m_echo = cfg_echo_en && !m_valid;
            end else if (m_busy) begin
                if (lv && m_adv) begin m_tx = m_tx << 1; m_adv = 0; end
                if (rt) begin
                    m_rx = {m_rx[14:0], m_p2[0]};
                    m_adv = 1;
                    m_cnt++;
                    if (m_cnt == (cfg_wide ? 16 : 8)) begin
                        dn = 1; m_busy = 0; m_cnt = 0;
                    end
                end
            end
            if (host_wr_en) begin
                m_data = host_wr_data; m_valid = 1;
            end else begin
                if (dn) m_data = cfg_wide ? m_rx : {8'h00, m_rx[7:0]};
                if (st) m_valid = 0;
            end
            if (dn) m_rbf = 1;
            else if (host_rd_en) m_rbf = 0;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = {sck_in, sel_n_in, sdi_in};
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            chk("R1 model oe", sdo_oe, !m_p2[1]);
            if (!m_p2[1])
                chk("R3/R5 model sdo", sdo_data, m_echo ? m_p2[0] : m_tx[15]);
            chk("R10 model busy", busy, m_busy);
            chk("R4 model rbf", rbf, m_rbf);
            chk("R4/R9 model data", host_rd_data, m_data);
            chk("R8 model irq", irq, (m_rbf && cfg_rd_irq_en) || (!m_busy && cfg_wr_irq_en));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [15:0] w);
        @(negedge clk); host_wr_en = 1'b1; host_wr_data = w;
        @(negedge clk); host_wr_en = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); host_rd_en = 1'b1;
        @(negedge clk); host_rd_en = 1'b0;
    endtask

    task automatic sel_on();
        @(negedge clk); sel_n_in = 1'b0; wait_n(HP);
    endtask

    task automatic sel_off();
        @(negedge clk); sel_n_in = 1'b1; wait_n(HP);
    endtask

    task automatic shift(input int n, input logic [15:0] mosi, output logic [15:0] miso);
        miso = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            sdi_in = mosi[i];
            sck_in = !cfg_idle_hi;
            wait_n(HP);
            miso[i] = sdo_data;
            sck_in = cfg_idle_hi;
            wait_n(HP);
        end
    endtask

    task automatic xfer(input int n, input logic [15:0] mosi, output logic [15:0] miso);
        sel_on();
        shift(n, mosi, miso);
        sel_off();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] miso;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        model_on = 1;
        // reset state
        chk("R1 reset oe", sdo_oe, 0);
        chk("R10 reset busy", busy, 0);
        chk("R4 reset rbf", rbf, 0);
        chk("R8 reset irq", irq, 0);

        // 8-bit, idle low
        host_write(16'h12A5);
        xfer(8, 16'h003C, miso);
        chk("R3 R7 8-bit msb first", miso[7:0], 8'hA5);
        chk("R4 8-bit receive", host_rd_data, 16'h003C);
        chk("R4 rbf set", rbf, 1);
        host_read();
        chk("R9 read clears rbf", rbf, 0);

        // 16-bit, idle high
        @(negedge clk); cfg_wide = 1'b1; cfg_idle_hi = 1'b1; sck_in = 1'b1;
        wait_n(4);
        host_write(16'hBEEF);
        xfer(16, 16'h1234, miso);
        chk("R3 R7 16-bit idle high send", miso, 16'hBEEF);
        chk("R4 16-bit receive", host_rd_data, 16'h1234);

        // echo with no valid data
        @(negedge clk); cfg_wide = 1'b0; cfg_idle_hi = 1'b0; sck_in = 1'b0; cfg_echo_en = 1'b1;
        wait_n(4);
        xfer(8, 16'h005A, miso);
        chk("R5 echo output", miso[7:0], 8'h5A);
        chk("R5 echo still stored", host_rd_data, 16'h005A);

        // echo off, stale data still sent
        @(negedge clk); cfg_echo_en = 1'b0;
        xfer(8, 16'h00C3, miso);
        chk("R6 stale data sent", miso[7:0], 8'h5A);
        chk("R4 receive after stale send", host_rd_data, 16'h00C3);

        // echo on, but a fresh write is valid
        @(negedge clk); cfg_echo_en = 1'b1;
        host_write(16'h0081);
        xfer(8, 16'h007E, miso);
        chk("R9 valid write beats echo", miso[7:0], 8'h81);

        // resynchronisation by releasing select
        @(negedge clk); cfg_echo_en = 1'b0;
        sel_on();
        shift(3, 16'h0005, miso);
        sel_off();
        chk("R10 busy cleared by release", busy, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); sck_in = 1'b1; wait_n(HP);
            @(negedge clk); sck_in = 1'b0; wait_n(HP);
        end
        chk("R2 clocks ignored while deselected", busy, 0);
        host_write(16'h0096);
        xfer(8, 16'h0069, miso);
        chk("R2 realigned send", miso[7:0], 8'h96);
        chk("R2 realigned receive", host_rd_data, 16'h0069);

        // interrupt sources
        host_read();
        @(negedge clk); cfg_wr_irq_en = 1'b1;
        wait_n(1);
        chk("R8 irq when idle", irq, 1);
        sel_on();
        shift(4, 16'h000A, miso);
        chk("R10 busy mid transfer", busy, 1);
        chk("R8 irq low while busy", irq, 0);
        shift(4, 16'h0005, miso);
        sel_off();
        chk("R4 split transfer receive", host_rd_data, 16'h00A5);
        @(negedge clk); cfg_wr_irq_en = 1'b0; cfg_rd_irq_en = 1'b1;
        wait_n(1);
        chk("R8 irq from rbf", irq, 1);
        host_read();
        chk("R8 irq drops after read", irq, 0);

        // back-to-back words under one selection
        host_write(16'h0011);
        sel_on();
        shift(8, 16'h0022, miso);
        chk("R11 first word", miso[7:0], 8'h11);
        shift(8, 16'h0033, miso);
        chk("R11 second word sends received", miso[7:0], 8'h22);
        sel_off();
        chk("R11 second word received", host_rd_data, 16'h0033);

        wait_n(4);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule